// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Reader

This block is the read path of a serial configuration memory. It holds a bitstream in an internal bit array and shifts it out, one bit for each rising edge of the serial clock, to a device that is loading its configuration. A chip-select input picks the memory. A combined reset/output-enable input does two jobs: it rewinds the read position and it gates the data driver. The active level of that input is chosen by a configuration bit, so it can be wired straight to either polarity of the loader's control pin.

Several of these readers can be chained. When a reader has clocked out its final bit, it releases its data line and pulls its chain-select output low. That output drives the chip select of the next reader, which then takes over the stream. A power-on interval, counted in clock cycles after the global reset, holds the block quiet and holds a ready indicator low. When the serial-programming enable is low, the streaming read is suspended. The array is filled through a simple write port.

Top module: `cfg_stream_reader`

## Requirements
- R1: After global reset is released, `ready_pull_low` stays 1 for exactly POR_CYCLES rising edges and then goes to 0 and stays there. While it is 1, `data_oe` is 0, `chain_en_n` is 1 and the read position is held at bit 0.
- R2: While the block is selected, the output shows the stored bit at the current read position. Each rising edge moves the position forward by one, so bits appear in ascending index order starting from index 0.
- R3: `data_oe` is 1 only when all of these hold: power-on is complete, `stream_en`=1, `ce_n`=0, the reset/output-enable input is at its non-reset level, and the final bit has not yet been passed. `data_out` is 0 whenever `data_oe` is 0.
- R4: A rising edge that sees the reset level on `rst_oe` (with `stream_en`=1) returns the read position to bit 0, and the end-of-array state is cleared.
- R5: With `rst_active_low`=0 the reset level is `rst_oe`=1. With `rst_active_low`=1 the reset level is `rst_oe`=0.
- R6: While `ce_n`=1, the read position does not move and `data_oe` is 0. When the block is selected again, the stream resumes at the same bit.
- R7: On the rising edge that reads the final bit (index DEPTH-1), `data_oe` falls to 0 and `chain_en_n` falls to 0. Further edges do not wrap the position; the block stays in this state until a reset level is applied.
- R8: Once the final bit has been read, `chain_en_n` equals `ce_n` as long as the reset level is absent. It goes to 1 as soon as the reset level appears, and it stays 1 until the whole array has been read again.
- R9: While `stream_en`=0, `data_oe` is 0 and `chain_en_n` is 1. The read position holds, whatever `ce_n` and `rst_oe` are doing.
- R10: A rising edge with `load_we`=1 stores `load_bit` at index `load_addr` of the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; rising edge advances the read position |
| rst_n | input | 1 | Global asynchronous reset, active low; starts the power-on interval |
| ce_n | input | 1 | Chip select, active low; high puts the block in standby |
| rst_oe | input | 1 | Combined reset / output-enable input, polarity set by `rst_active_low` |
| rst_active_low | input | 1 | 0: reset level is high; 1: reset level is low |
| stream_en | input | 1 | 1: normal streaming read; 0: programming mode, reading suspended |
| load_we | input | 1 | Array write strobe |
| load_addr | input | AW | Array write index, AW = ceil(log2(DEPTH)) |
| load_bit | input | 1 | Array write data |
| data_out | output | 1 | Serial data value, 0 when not driven |
| data_oe | output | 1 | Data driver enable (tri-state control) |
| chain_en_n | output | 1 | Chain select for the next reader, active low |
| ready_pull_low | output | 1 | Open-drain enable: 1 pulls the ready line low during power-on |

## Verification
The checker watches several rules on every clock. It checks that the data driver is never enabled unless the block is selected, out of reset level, in streaming mode and past power-on. It checks that the data value is zero when the driver is off and that a low chain select never coincides with an enabled driver. It also checks that ready never re-asserts once released and that a spent reader stays silent on the next cycle. Other properties can only be shown by the bench's directed scenarios, because they depend on the stored pattern and on the history of inputs: the exact bit order, rewinding at mid-stream, resuming after standby or programming mode, the non-wrapping end state, both reset polarities, the follow phase of the chain select, and rewrites of the array.

// File: rtl/cfg_rd_pkg.sv
package cfg_rd_pkg;

    typedef enum logic [0:0] {
        SEQ_STREAM = 1'b0,
        SEQ_SPENT  = 1'b1
    } seq_phase_e;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cfg_por_timer.sv
module cfg_por_timer #(
    parameter int POR_CYCLES = 16,
    localparam int CW = $clog2(POR_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    output logic por_done
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } por_t;

    por_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CW'(POR_CYCLES - 1)) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign por_done = st_q.done;

endmodule

// File: rtl/cfg_bit_store.sv
module cfg_bit_store #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);

    logic [DEPTH-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en && (int'(wr_addr) < DEPTH)) mem_d[wr_addr] = wr_bit;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_bit = mem_q[rd_addr];

endmodule

// File: rtl/cfg_read_seq.sv
module cfg_read_seq
    import cfg_rd_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_done,
    input  logic          stream_en,
    input  logic          ce_n,
    input  logic          rst_hit,
    output logic [AW-1:0] addr,
    output seq_phase_e    phase
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        seq_phase_e    phase;
        logic [AW-1:0] addr;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!por_done || (stream_en && rst_hit)) begin
            st_d.addr  = '0;
            st_d.phase = SEQ_STREAM;
        end else if (stream_en && !ce_n && st_q.phase == SEQ_STREAM) begin
            if (st_q.addr == LAST) st_d.phase = SEQ_SPENT;
            else                   st_d.addr  = st_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: SEQ_STREAM, addr: '0};
        else        st_q <= st_d;
    end

    assign addr  = st_q.addr;
    assign phase = st_q.phase;

endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader
    import cfg_rd_pkg::*;
#(
    parameter int DEPTH      = 1024,
    parameter int POR_CYCLES = 16,
    localparam int AW        = idx_w(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          rst_oe,
    input  logic          rst_active_low,
    input  logic          stream_en,
    input  logic          load_we,
    input  logic [AW-1:0] load_addr,
    input  logic          load_bit,
    output logic          data_out,
    output logic          data_oe,
    output logic          chain_en_n,
    output logic          ready_pull_low
);

    logic          por_done;
    logic          rst_hit;
    logic          selected;
    logic          cur_bit;
    logic [AW-1:0] rd_addr;
    seq_phase_e    phase;

    // reset level of the shared pin, polarity chosen by the config bit
    assign rst_hit  = rst_oe ^ rst_active_low;
    assign selected = por_done & stream_en & ~ce_n & ~rst_hit;

    cfg_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk      (clk),
        .rst_n    (rst_n),
        .por_done (por_done)
    );

    cfg_read_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_done  (por_done),
        .stream_en (stream_en),
        .ce_n      (ce_n),
        .rst_hit   (rst_hit),
        .addr      (rd_addr),
        .phase     (phase)
    );

    cfg_bit_store #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk     (clk),
        .wr_en   (load_we),
        .wr_addr (load_addr),
        .wr_bit  (load_bit),
        .rd_addr (rd_addr),
        .rd_bit  (cur_bit)
    );

    assign data_oe        = selected & (phase == SEQ_STREAM);
    assign data_out       = data_oe & cur_bit;
    assign chain_en_n     = ~(selected & (phase == SEQ_SPENT));
    assign ready_pull_low = ~por_done;

endmodule

// File: rtl/cfg_stream_reader_chk.sv
module cfg_stream_reader_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic rst_oe,
    input logic rst_active_low,
    input logic stream_en,
    input logic data_out,
    input logic data_oe,
    input logic chain_en_n,
    input logic ready_pull_low
);

    // R3
    drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!ce_n && stream_en && !ready_pull_low && ((rst_oe ^ rst_active_low) == 1'b0)));

    // R3
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> !data_out);

    // R8
    chain_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_en_n |-> (!ce_n && !data_oe && stream_en));

    // R1
    por_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_pull_low |-> (!data_oe && chain_en_n));

    // R1
    ready_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_pull_low |=> !ready_pull_low);

    // R7
    spent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_en_n |=> !data_oe);

endmodule

bind cfg_stream_reader cfg_stream_reader_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ce_n           (ce_n),
    .rst_oe         (rst_oe),
    .rst_active_low (rst_active_low),
    .stream_en      (stream_en),
    .data_out       (data_out),
    .data_oe        (data_oe),
    .chain_en_n     (chain_en_n),
    .ready_pull_low (ready_pull_low)
);

// File: tb/sim_cfg_stream_reader.sv
`timescale 1ns/1ps
module sim_cfg_stream_reader;

    localparam int DEPTH = 24;
    localparam int POR   = 6;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n, ce_n, rst_oe, rst_active_low, stream_en;
    logic load_we, load_bit;
    logic [AW-1:0] load_addr;
    logic data_out, data_oe, chain_en_n, ready_pull_low;

    int n_chk  = 0;
    int n_fail = 0;
    logic exp_bits [DEPTH];

    always #2 clk = ~clk;

    cfg_stream_reader #(.DEPTH(DEPTH), .POR_CYCLES(POR)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rst_oe(rst_oe),
        .rst_active_low(rst_active_low), .stream_en(stream_en),
        .load_we(load_we), .load_addr(load_addr), .load_bit(load_bit),
        .data_out(data_out), .data_oe(data_oe), .chain_en_n(chain_en_n),
        .ready_pull_low(ready_pull_low)
    );

    function automatic logic pat(input int i);
        return ((i * 5 + 2) % 7) < 3;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // expects the bit at index k on the line
    task automatic chk_bit(input string req, input int k);
        chk(req, $sformatf("oe at bit %0d", k), data_oe, 1'b1);
        chk(req, $sformatf("value at bit %0d", k), data_out, exp_bits[k]);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic t_reset_por();
        rst_n = 1'b0; ce_n = 1'b0; rst_oe = 1'b0; rst_active_low = 1'b0;
        stream_en = 1'b1; load_we = 1'b0; load_addr = '0; load_bit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            exp_bits[i] = pat(i);
            load_we = 1'b1; load_addr = AW'(i); load_bit = pat(i);
            tick();
        end
        load_we = 1'b0;
        #1;
        chk("R1", "ready in reset", ready_pull_low, 1'b1);
        chk("R1", "oe in reset", data_oe, 1'b0);
        chk("R1", "chain in reset", chain_en_n, 1'b1);
        rst_n = 1'b1;
        for (int e = 1; e <= POR; e++) begin
            tick();
            chk("R1", $sformatf("ready after %0d edges", e), ready_pull_low, (e < POR));
            if (e < POR) chk("R1", "oe during por", data_oe, 1'b0);
        end
        chk_bit("R1", 0);
    endtask

    task automatic t_full_stream();
        for (int k = 0; k < DEPTH; k++) begin
            chk_bit("R2", k);
            chk("R2", "chain high mid-stream", chain_en_n, 1'b1);
            tick();
        end
        chk("R7", "oe after last", data_oe, 1'b0);
        chk("R7", "chain after last", chain_en_n, 1'b0);
        tick(); tick();
        chk("R7", "no wrap oe", data_oe, 1'b0);
        chk("R7", "no wrap chain", chain_en_n, 1'b0);
    endtask

    task automatic t_chain_phases();
        ce_n = 1'b1; #1;
        chk("R8", "chain follows ce high", chain_en_n, 1'b1);
        tick();
        ce_n = 1'b0; #1;
        chk("R8", "chain follows ce low", chain_en_n, 1'b0);
        chk("R8", "oe while spent", data_oe, 1'b0);
        rst_oe = 1'b1; #1;
        chk("R8", "chain high on reset", chain_en_n, 1'b1);
        chk("R3", "oe off in reset", data_oe, 1'b0);
        tick();
        rst_oe = 1'b0; #1;
        chk("R8", "chain stays high after rewind", chain_en_n, 1'b1);
        chk_bit("R4", 0);
    endtask

    task automatic t_mid_rewind();
        for (int k = 0; k < 5; k++) tick();
        chk_bit("R2", 5);
        rst_oe = 1'b1; tick();
        rst_oe = 1'b0; #1;
        chk_bit("R4", 0);
    endtask

    task automatic t_standby();
        tick(); tick(); tick();
        chk_bit("R2", 3);
        ce_n = 1'b1; #1;
        chk("R6", "oe in standby", data_oe, 1'b0);
        chk("R6", "chain in standby", chain_en_n, 1'b1);
        tick(); tick(); tick();
        ce_n = 1'b0; #1;
        chk_bit("R6", 3);
    endtask

    task automatic t_prog_mode();
        stream_en = 1'b0; rst_oe = 1'b1; #1;
        chk("R9", "oe in prog mode", data_oe, 1'b0);
        chk("R9", "chain in prog mode", chain_en_n, 1'b1);
        tick(); tick(); tick();
        stream_en = 1'b1; rst_oe = 1'b0; #1;
        chk_bit("R9", 3);
    endtask

    task automatic t_polarity();
        rst_active_low = 1'b1; #1;
        chk("R5", "low rst_oe is reset level", data_oe, 1'b0);
        tick();
        rst_oe = 1'b1; #1;
        chk_bit("R5", 0);
        tick(); tick();
        chk_bit("R5", 2);
        rst_oe = 1'b0; tick();
        rst_oe = 1'b1; #1;
        chk_bit("R5", 0);
        for (int k = 0; k < DEPTH; k++) tick();
        chk("R7", "chain low with low-active reset", chain_en_n, 1'b0);
        rst_oe = 1'b0; #1;
        chk("R8", "chain high on low reset level", chain_en_n, 1'b1);
        tick();
        rst_oe = 1'b1; rst_active_low = 1'b0; rst_oe = 1'b0; #1;
        chk_bit("R5", 0);
    endtask

    task automatic t_reload();
        ce_n = 1'b1;
        exp_bits[1] = ~pat(1);
        load_we = 1'b1; load_addr = AW'(1); load_bit = ~pat(1);
        tick();
        load_we = 1'b0;
        rst_oe = 1'b1; tick();
        rst_oe = 1'b0; ce_n = 1'b0; #1;
        chk_bit("R10", 0);
        tick();
        chk_bit("R10", 1);
    endtask

    initial begin
        t_reset_por();
        t_full_stream();
        t_chain_phases();
        t_mid_rewind();
        t_standby();
        t_prog_mode();
        t_polarity();
        t_reload();
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule